// File: doc/BRIEF.md
# Saturating Line-Error Counter Bank

This block holds four error counters for a T1 line receiver. One counter is 16 bits wide and counts bipolar violations, or runs of excess zeros when that mode is selected. Three counters are 8 bits wide and count CRC word errors, out-of-frame events and framing-bit errors. Upstream line logic supplies each event as a one-cycle pulse. This block only accumulates the pulses; it does not detect the events.

A host uses a single-cycle register port to access the counters. The host can preset a counter to any value, which sets how many further events raise an alarm. A counter counts upward from its value and never wraps. When an event arrives while a counter is already at full scale, a sticky saturation flag is set for that counter. That flag can drive an interrupt, and each flag has its own enable. Counting depends on the framing mode and on the loss-of-sync state.

When the auto-clear option is on, every host read clears all four counters. The read still returns the values from before the read. An event that arrives in the same cycle as the read is counted after the clear, so no event is lost.

Top module: `err_cnt_bank`

## Requirements
- R1: The violation counter is 16 bits wide. Each counted event adds one, up to 65535. At 65535 the counter holds its value.
- R2: The CRC counter (address 2), the out-of-frame counter (address 3) and the frame-error counter (address 4) are each 8 bits wide. Each adds one per counted event and holds at 255.
- R3: An event that arrives while its counter is at full scale sets a sticky flag. The flag bits are: bit 0 violation, bit 1 CRC, bit 2 out-of-frame, bit 3 frame-error. A read of address 5 returns the flags and then clears them. A flag that is hit again in that same cycle stays set.
- R4: `irq` is high exactly when some set flag has its `sat_mask` bit at 1.
- R5: A host write to address 2, 3 or 4 loads that counter. A write to address 0 only stores the low byte of the violation counter. The full 16-bit value is loaded when address 1 (the high byte) is written. Reads of address 0 and 1 return the low and high bytes, one cycle after `host_rd`.
- R6: With `cfg_xs_zero` at 0, the violation counter counts `ev_bpv`, except when `ev_code_word` is also high and `cfg_zsub` is 1. With `cfg_xs_zero` at 1, it counts only `ev_zero8` when `cfg_zsub` is 1, and only `ev_zero16` when `cfg_zsub` is 0.
- R7: While `sync_lost` is 1, the CRC, out-of-frame and frame-error counters hold their values. The violation counter keeps counting.
- R8: While `cfg_esf` is 0, the CRC counter is held at zero and ignores events and writes.
- R9: The frame-error counter always counts `ev_ft_err`. It also counts `ev_fs_err` when `cfg_fe_both` is 1. Two errors in the same cycle add one.
- R10: With `cfg_auto_clr` at 1, any read returns the value from before the read and clears all four counters. An event that arrives in the read cycle leaves its counter at 1.
- R11: After reset, all counters, all flags and `irq` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line-rate clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_bpv | input | 1 | Bipolar violation pulse |
| ev_code_word | input | 1 | Marks the current violation as part of a substitution code word |
| ev_zero8 | input | 1 | Run of 8 zeros pulse |
| ev_zero16 | input | 1 | Run of 16 zeros pulse |
| ev_crc | input | 1 | CRC word error pulse |
| ev_oof | input | 1 | Out-of-frame event pulse |
| ev_ft_err | input | 1 | Frame-pattern bit error pulse |
| ev_fs_err | input | 1 | Signaling-pattern bit error pulse |
| sync_lost | input | 1 | Resync in progress |
| cfg_esf | input | 1 | 1 = 24-frame mode, 0 = 12-frame mode |
| cfg_zsub | input | 1 | Zero substitution enabled |
| cfg_xs_zero | input | 1 | Violation counter counts zero runs instead of violations |
| cfg_fe_both | input | 1 | Frame-error counter also counts signaling-pattern errors |
| cfg_auto_clr | input | 1 | Clear all counters on any read |
| sat_mask | input | 4 | Interrupt enable for each flag |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe |
| host_addr | input | 3 | Register address |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, registered |
| host_rvalid | output | 1 | host_rdata valid |
| sat_flags | output | 4 | Sticky saturation flags |
| irq | output | 1 | Interrupt request |

## Verification
The violation counter is driven with plain violations, with violations that coincide with code words, and with runs of 8 and 16 zeros. This shows that each setting of the two mode inputs picks the right source. Presets near full scale, followed by a few events, separate saturation from wrap-around. A read of the low byte taken between the two preset writes shows whether the 16-bit load is staged. Events applied while sync is lost and in 12-frame mode show which counters hold. A read that coincides with an out-of-frame event under auto-clear shows whether the pre-read snapshot and the post-clear count both come out right.

// File: rtl/errbank_pkg.sv
package errbank_pkg;
   localparam int ADDR_W  = 3;
   localparam int N_CNT   = 4;
   localparam int IDX_BPV = 0;
   localparam int IDX_CRC = 1;
   localparam int IDX_OOF = 2;
   localparam int IDX_FE  = 3;

   localparam logic [ADDR_W-1:0] A_BPV_LO = 3'd0;
   localparam logic [ADDR_W-1:0] A_BPV_HI = 3'd1;
   localparam logic [ADDR_W-1:0] A_CRC    = 3'd2;
   localparam logic [ADDR_W-1:0] A_OOF    = 3'd3;
   localparam logic [ADDR_W-1:0] A_FE     = 3'd4;
   localparam logic [ADDR_W-1:0] A_STAT   = 3'd5;
endpackage

// File: rtl/err_evt_gate.sv
module err_evt_gate
   import errbank_pkg::*;
(
   input  logic             ev_bpv,
   input  logic             ev_code_word,
   input  logic             ev_zero8,
   input  logic             ev_zero16,
   input  logic             ev_crc,
   input  logic             ev_oof,
   input  logic             ev_ft_err,
   input  logic             ev_fs_err,
   input  logic             sync_lost,
   input  logic             cfg_esf,
   input  logic             cfg_zsub,
   input  logic             cfg_xs_zero,
   input  logic             cfg_fe_both,
   output logic [N_CNT-1:0] inc
);
   logic viol_src;
   logic zero_src;
   logic in_sync;

   always_comb begin
      in_sync  = ~sync_lost;
      viol_src = ev_bpv & ~(cfg_zsub & ev_code_word);
      zero_src = cfg_zsub ? ev_zero8 : ev_zero16;
      inc          = '0;
      inc[IDX_BPV] = cfg_xs_zero ? zero_src : viol_src;
      inc[IDX_CRC] = ev_crc & cfg_esf & in_sync;
      inc[IDX_OOF] = ev_oof & in_sync;
      inc[IDX_FE]  = (ev_ft_err | (cfg_fe_both & ev_fs_err)) & in_sync;
   end
endmodule

// File: rtl/err_sat_counter.sv
module err_sat_counter #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   input  logic         clr,
   input  logic         force_zero,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic [W-1:0] cnt,
   output logic         sat_hit
);
   localparam logic [W-1:0] FULL = {W{1'b1}};
   localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

   generate
      if (W < 2) begin : g_bad_width
         $error("err_sat_counter: W must be at least 2");
      end
   endgenerate

   logic at_full;
   assign at_full = (cnt == FULL);
   assign sat_hit = inc & at_full & ~clr & ~load & ~force_zero;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (force_zero) cnt <= '0;
      else if (load)       cnt <= load_val;
      else if (clr)        cnt <= inc ? ONE : '0;
      else if (inc && !at_full) cnt <= cnt + ONE;
   end

   AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (at_full && !clr && !load && !force_zero) |=> (cnt == FULL)); // R1

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc && !clr && !load && !force_zero) |=> $stable(cnt)); // R2

   AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !at_full && !clr && !load && !force_zero) |=> (cnt == $past(cnt) + ONE)); // R2
endmodule

// File: rtl/err_cnt_bank.sv
module err_cnt_bank
   import errbank_pkg::*;
#(
   parameter int REG_W = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   ev_bpv,
   input  logic                   ev_code_word,
   input  logic                   ev_zero8,
   input  logic                   ev_zero16,
   input  logic                   ev_crc,
   input  logic                   ev_oof,
   input  logic                   ev_ft_err,
   input  logic                   ev_fs_err,
   input  logic                   sync_lost,
   input  logic                   cfg_esf,
   input  logic                   cfg_zsub,
   input  logic                   cfg_xs_zero,
   input  logic                   cfg_fe_both,
   input  logic                   cfg_auto_clr,
   input  logic [N_CNT-1:0]       sat_mask,
   input  logic                   host_wr,
   input  logic                   host_rd,
   input  logic [ADDR_W-1:0]      host_addr,
   input  logic [REG_W-1:0]       host_wdata,
   output logic [REG_W-1:0]       host_rdata,
   output logic                   host_rvalid,
   output logic [N_CNT-1:0]       sat_flags,
   output logic                   irq
);
   localparam int BPV_W = 2 * REG_W;
   localparam int ERR_W = REG_W;

   generate
      if (REG_W < N_CNT) begin : g_bad_reg_w
         $error("err_cnt_bank: REG_W must hold the flag vector");
      end
   endgenerate

   logic [N_CNT-1:0] inc;
   logic [N_CNT-1:0] sat_hit;
   logic [REG_W-1:0] lo_stage;
   logic [BPV_W-1:0] bpv_cnt;
   logic [ERR_W-1:0] err_cnt [1:N_CNT-1];
   logic             rd_clr;
   logic             stat_rd;
   logic [REG_W-1:0] rd_mux;

   assign rd_clr  = host_rd & cfg_auto_clr;
   assign stat_rd = host_rd & (host_addr == A_STAT);

   err_evt_gate u_gate (
      .ev_bpv       (ev_bpv),
      .ev_code_word (ev_code_word),
      .ev_zero8     (ev_zero8),
      .ev_zero16    (ev_zero16),
      .ev_crc       (ev_crc),
      .ev_oof       (ev_oof),
      .ev_ft_err    (ev_ft_err),
      .ev_fs_err    (ev_fs_err),
      .sync_lost    (sync_lost),
      .cfg_esf      (cfg_esf),
      .cfg_zsub     (cfg_zsub),
      .cfg_xs_zero  (cfg_xs_zero),
      .cfg_fe_both  (cfg_fe_both),
      .inc          (inc)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                lo_stage <= '0;
      else if (host_wr && host_addr == A_BPV_LO) lo_stage <= host_wdata;
   end

   err_sat_counter #(.W(BPV_W)) u_bpv_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .inc        (inc[IDX_BPV]),
      .clr        (rd_clr),
      .force_zero (1'b0),
      .load       (host_wr && host_addr == A_BPV_HI),
      .load_val   ({host_wdata, lo_stage}),
      .cnt        (bpv_cnt),
      .sat_hit    (sat_hit[IDX_BPV])
   );

   generate
      for (genvar i = 1; i < N_CNT; i++) begin : g_err
         localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(i + 1);
         logic fz;
         if (i == IDX_CRC) begin : g_crc_gate
            assign fz = ~cfg_esf;
         end else begin : g_no_gate
            assign fz = 1'b0;
         end
         err_sat_counter #(.W(ERR_W)) u_cnt (
            .clk        (clk),
            .rst_n      (rst_n),
            .inc        (inc[i]),
            .clr        (rd_clr),
            .force_zero (fz),
            .load       (host_wr && host_addr == MY_ADDR),
            .load_val   (host_wdata),
            .cnt        (err_cnt[i]),
            .sat_hit    (sat_hit[i])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       sat_flags <= '0;
      else if (stat_rd) sat_flags <= sat_hit;
      else              sat_flags <= sat_flags | sat_hit;
   end

   assign irq = |(sat_flags & sat_mask);

   always_comb begin
      rd_mux = '0;
      case (host_addr)
         A_BPV_LO: rd_mux = bpv_cnt[REG_W-1:0];
         A_BPV_HI: rd_mux = bpv_cnt[BPV_W-1:REG_W];
         A_CRC:    rd_mux = err_cnt[IDX_CRC];
         A_OOF:    rd_mux = err_cnt[IDX_OOF];
         A_FE:     rd_mux = err_cnt[IDX_FE];
         A_STAT:   rd_mux = REG_W'(sat_flags);
         default:  rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         host_rdata  <= '0;
         host_rvalid <= 1'b0;
      end else begin
         host_rvalid <= host_rd;
         if (host_rd) host_rdata <= rd_mux;
      end
   end

   AST_CRC_ZERO_SF: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_esf |=> (err_cnt[IDX_CRC] == '0)); // R8

   AST_SYNC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_lost && !host_wr && !rd_clr && cfg_esf) |=> $stable(err_cnt[IDX_OOF]) && $stable(err_cnt[IDX_FE])); // R7

   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (sat_flags[IDX_OOF] && !stat_rd) |=> sat_flags[IDX_OOF]); // R3

   AST_AUTOCLR: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_clr && !host_wr) |=> (err_cnt[IDX_OOF] <= ERR_W'(1)) && (bpv_cnt <= BPV_W'(1))); // R10
endmodule

// File: tb/err_cnt_bank_bench.sv
module err_cnt_bank_bench;
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ev_bpv = 0, ev_code_word = 0, ev_zero8 = 0, ev_zero16 = 0;
   logic ev_crc = 0, ev_oof = 0, ev_ft_err = 0, ev_fs_err = 0;
   logic sync_lost = 0, cfg_esf = 1, cfg_zsub = 0, cfg_xs_zero = 0;
   logic cfg_fe_both = 0, cfg_auto_clr = 0;
   logic [3:0] sat_mask = 4'hF;
   logic host_wr = 0, host_rd = 0;
   logic [2:0] host_addr = '0;
   logic [7:0] host_wdata = '0;
   logic [7:0] host_rdata;
   logic host_rvalid;
   logic [3:0] sat_flags;
   logic irq;

   int checks = 0;
   int failures = 0;
   logic [7:0] exp_q [$];
   string tag_q [$];

   always #(CLK_PERIOD/2) clk = ~clk;

   err_cnt_bank u_err_cnt_bank (
      .clk(clk), .rst_n(rst_n),
      .ev_bpv(ev_bpv), .ev_code_word(ev_code_word), .ev_zero8(ev_zero8),
      .ev_zero16(ev_zero16), .ev_crc(ev_crc), .ev_oof(ev_oof),
      .ev_ft_err(ev_ft_err), .ev_fs_err(ev_fs_err), .sync_lost(sync_lost),
      .cfg_esf(cfg_esf), .cfg_zsub(cfg_zsub), .cfg_xs_zero(cfg_xs_zero),
      .cfg_fe_both(cfg_fe_both), .cfg_auto_clr(cfg_auto_clr),
      .sat_mask(sat_mask), .host_wr(host_wr), .host_rd(host_rd),
      .host_addr(host_addr), .host_wdata(host_wdata),
      .host_rdata(host_rdata), .host_rvalid(host_rvalid),
      .sat_flags(sat_flags), .irq(irq)
   );

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // monitor: pops expected read data as results appear
   always @(negedge clk) begin
      if (rst_n && host_rvalid) begin
         if (exp_q.size() == 0) begin
            checks++; failures++;
            $display("FAIL scoreboard unexpected read actual=%0h expected=none", host_rdata);
         end else begin
            check(tag_q.pop_front(), host_rdata, exp_q.pop_front());
         end
      end
   end

   task automatic host_read(input logic [2:0] a, input logic [7:0] exp, input string tag);
      host_rd = 1; host_addr = a;
      exp_q.push_back(exp); tag_q.push_back(tag);
      @(negedge clk);
      host_rd = 0;
   endtask

   task automatic host_write(input logic [2:0] a, input logic [7:0] d);
      host_wr = 1; host_addr = a; host_wdata = d;
      @(negedge clk);
      host_wr = 0;
   endtask

   // v = {fs, ft, oof, crc, z16, z8, code, bpv}
   task automatic pulse(input logic [7:0] v, input int n);
      for (int k = 0; k < n; k++) begin
         {ev_fs_err, ev_ft_err, ev_oof, ev_crc, ev_zero16, ev_zero8, ev_code_word, ev_bpv} = v;
         @(negedge clk);
         {ev_fs_err, ev_ft_err, ev_oof, ev_crc, ev_zero16, ev_zero8, ev_code_word, ev_bpv} = '0;
      end
   endtask

   localparam logic [7:0] P_BPV  = 8'h01, P_CODE = 8'h02, P_Z8 = 8'h04, P_Z16 = 8'h08;
   localparam logic [7:0] P_CRC  = 8'h10, P_OOF  = 8'h20, P_FT = 8'h40, P_FS  = 8'h80;

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : stimulus
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R11 reset state
      check("R11 irq after reset", {7'd0, irq}, 8'h00);
      check("R11 flags after reset", {4'd0, sat_flags}, 8'h00);
      for (int a = 0; a < 6; a++) host_read(3'(a), 8'h00, "R11 reg after reset");

      // R1 basic counting
      pulse(P_BPV, 5);
      host_read(3'd0, 8'h05, "R1 bpv low after 5");
      host_read(3'd1, 8'h00, "R1 bpv high after 5");

      // R5 staged 16-bit preset
      host_write(3'd0, 8'hFD);
      host_read(3'd0, 8'h05, "R5 low write alone not applied");
      host_write(3'd1, 8'hFF);
      host_read(3'd0, 8'hFD, "R5 low byte after high write");
      host_read(3'd1, 8'hFF, "R5 high byte after high write");

      // R1 saturation, R3 flag, R4 irq
      pulse(P_BPV, 2);
      check("R4 irq before saturation event", {7'd0, irq}, 8'h00);
      pulse(P_BPV, 1);
      check("R4 irq after saturation event", {7'd0, irq}, 8'h01);
      host_read(3'd0, 8'hFF, "R1 bpv low held at full");
      host_read(3'd1, 8'hFF, "R1 bpv high held at full");
      host_read(3'd5, 8'h01, "R3 status shows bpv flag");
      host_read(3'd5, 8'h00, "R3 status cleared by read");
      check("R4 irq after status read", {7'd0, irq}, 8'h00);

      // R6 code-word exclusion
      host_write(3'd0, 8'h00);
      host_write(3'd1, 8'h00);
      cfg_zsub = 1;
      pulse(P_BPV | P_CODE, 1);
      pulse(P_BPV, 1);
      cfg_zsub = 0;
      pulse(P_BPV | P_CODE, 1);
      host_read(3'd0, 8'h02, "R6 code word excluded only with zsub");

      // R6 excess-zero mode
      cfg_xs_zero = 1; cfg_zsub = 1;
      pulse(P_Z16, 1);
      pulse(P_Z8, 1);
      pulse(P_BPV, 1);
      cfg_zsub = 0;
      pulse(P_Z8, 1);
      pulse(P_Z16, 1);
      cfg_xs_zero = 0;
      host_read(3'd0, 8'h04, "R6 zero-run source selection");

      // R8 crc held at zero in 12-frame mode
      cfg_esf = 0;
      pulse(P_CRC, 2);
      host_write(3'd2, 8'h40);
      host_read(3'd2, 8'h00, "R8 crc zero in 12-frame mode");
      cfg_esf = 1;
      pulse(P_CRC, 3);
      host_read(3'd2, 8'h03, "R8 crc counts in 24-frame mode");

      // R7 loss of sync gating
      sync_lost = 1;
      pulse(P_CRC, 1);
      pulse(P_BPV, 1);
      pulse(P_OOF, 1);
      pulse(P_FT, 1);
      sync_lost = 0;
      host_read(3'd2, 8'h03, "R7 crc held during sync loss");
      host_read(3'd0, 8'h05, "R7 bpv counts during sync loss");
      host_read(3'd3, 8'h00, "R7 oof held during sync loss");
      host_read(3'd4, 8'h00, "R7 fe held during sync loss");

      // R9 frame-error source selection
      cfg_fe_both = 0;
      pulse(P_FT, 1);
      pulse(P_FS, 2);
      host_read(3'd4, 8'h01, "R9 fs ignored when not selected");
      cfg_fe_both = 1;
      pulse(P_FS, 1);
      pulse(P_FT | P_FS, 1);
      host_read(3'd4, 8'h03, "R9 both patterns counted once per cycle");

      // R2 8-bit saturation, R4 masking
      host_write(3'd3, 8'hFE);
      pulse(P_OOF, 1);
      host_read(3'd5, 8'h00, "R2 no flag on reaching full");
      sat_mask = 4'b1011;
      pulse(P_OOF, 1);
      check("R4 irq masked", {7'd0, irq}, 8'h00);
      check("R3 oof flag bit 2", {4'd0, sat_flags}, 8'h04);
      host_read(3'd3, 8'hFF, "R2 oof held at 255");
      host_read(3'd5, 8'h04, "R3 status oof flag");
      sat_mask = 4'hF;

      // R10 auto clear with coincident event
      cfg_auto_clr = 1;
      host_rd = 1; host_addr = 3'd4; ev_oof = 1;
      exp_q.push_back(8'h03); tag_q.push_back("R10 snapshot before clear");
      @(negedge clk);
      host_rd = 0; ev_oof = 0;
      host_read(3'd3, 8'h01, "R10 coincident event kept after clear");
      host_read(3'd0, 8'h00, "R10 bpv cleared");
      host_read(3'd2, 8'h00, "R10 crc cleared");
      host_read(3'd4, 8'h00, "R10 fe cleared");
      cfg_auto_clr = 0;

      repeat (3) @(negedge clk);
      if (exp_q.size() != 0) begin
         checks++; failures++;
         $display("FAIL scoreboard pending actual=%0d expected=0", exp_q.size());
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule